// File: doc/BRIEF.md
# Encoded-Control Arithmetic Logic Unit

This block is a stateless 32-bit arithmetic logic unit. It takes two operands and a 4-bit operation code, and it returns a 32-bit result and a flag that shows whether that result is zero. It offers five operations: bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than. The operation codes are sparse. Any code outside the five defined ones gives a result of zero.

Subtraction and the less-than compare share one adder. That adder adds the inverted second operand and a carry-in of one. The compare takes the sign of the difference and corrects it when the two operand signs differ, so wrap-around in the difference never gives a wrong answer. There is no clock, register or handshake. The outputs settle from the present inputs alone. The block sits directly in a datapath between the operand multiplexers and the result bus.

Top module: `enc_alu`

## Requirements
- R1: Code 4'b0000 drives result_out with the bitwise AND of a_in and b_in.
- R2: Code 4'b0001 drives result_out with the bitwise OR of a_in and b_in.
- R3: Code 4'b0010 drives result_out with a_in plus b_in, modulo 2^32. A carry beyond bit 31 is dropped without any indication.
- R4: Code 4'b0110 drives result_out with a_in minus b_in, modulo 2^32, formed as a_in plus the inverted b_in plus one.
- R5: Code 4'b0111 drives result_out with 1 when a_in is less than b_in and with 0 otherwise, with both operands read as signed two's-complement values. Bits 31 to 1 of the result are always zero for this code.
- R6: Every other code, including 4'b0011, 4'b0100, 4'b0101 and 4'b1000 to 4'b1111, drives result_out with all zeros.
- R7: zero_out is 1 exactly when all 32 bits of result_out are 0.
- R8: The outputs depend only on the present values of a_in, b_in and op_sel. The same inputs give the same outputs whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand |
| op_sel | input | 4 | Operation code |
| result_out | output | 32 | Operation result |
| zero_out | output | 1 | High when result_out is all zeros |

## Verification
The assertions are checked whenever an input changes. They confirm that an addition result minus b_in gives back a_in, and that a subtraction result plus b_in gives back a_in. They also confirm that a compare result uses at most bit 0, that equal or sign-separated operands give the expected compare outcome, that undefined codes give zero, and that the zero flag agrees with the result. The exact bit patterns need the bench's scenarios. These cover wrap-around at the extreme signed values, compares where the difference overflows, and the same inputs applied again after different histories.

// File: rtl/enc_alu_pkg.sv
package enc_alu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111
  } alu_op_e;

  // Codes that route the second operand through the inverter with carry-in set
  function automatic logic needs_negate(input logic [OP_W-1:0] code);
    return (code == OP_SUB) || (code == OP_SLT);
  endfunction
endpackage

// File: rtl/enc_alu_logic.sv
module enc_alu_logic #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      assign and_o[g] = x_i[g] & y_i[g];
      assign or_o[g]  = x_i[g] | y_i[g];
    end
  endgenerate
endmodule

// File: rtl/enc_alu_addsub.sv
module enc_alu_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             negate_i,
  output logic [WIDTH-1:0] sum_o
);
  logic [WIDTH-1:0] y_eff;
  logic [WIDTH-1:0] cin_vec;

  // Two's-complement negation folded into the adder: invert, then carry in one
  assign y_eff   = y_i ^ {WIDTH{negate_i}};
  assign cin_vec = {{(WIDTH-1){1'b0}}, negate_i};
  assign sum_o   = x_i + y_eff + cin_vec;
endmodule

// File: rtl/enc_alu_less.sv
module enc_alu_less #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             x_sign_i,
  input  logic             y_sign_i,
  input  logic             diff_sign_i,
  output logic             less_o
);
  // Opposite signs: the negative operand is smaller, and the difference may wrap.
  // Same signs: the difference cannot overflow, so its sign decides.
  assign less_o = (x_sign_i != y_sign_i) ? x_sign_i : diff_sign_i;
endmodule

// File: rtl/enc_alu_zero.sv
module enc_alu_zero #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned CHUNK = 8
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             zero_o
);
  localparam int unsigned NCH = (WIDTH + CHUNK - 1) / CHUNK;
  localparam int unsigned PADW = NCH * CHUNK;

  logic [PADW-1:0] padded;
  logic [NCH-1:0]  chunk_any;

  assign padded = {{(PADW-WIDTH){1'b0}}, vec_i};

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_chunk
      assign chunk_any[g] = |padded[g*CHUNK +: CHUNK];
    end
  endgenerate

  assign zero_o = ~|chunk_any;
endmodule

// File: rtl/enc_alu.sv
module enc_alu
  import enc_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned ZCHUNK = 8
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [3:0]       op_sel,
  output logic [WIDTH-1:0] result_out,
  output logic             zero_out
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] and_v;
  logic [WIDTH-1:0] or_v;
  logic [WIDTH-1:0] arith_v;
  logic             negate;
  logic             less;

  assign negate = needs_negate(op_sel);

  enc_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .x_i   (a_in),
    .y_i   (b_in),
    .and_o (and_v),
    .or_o  (or_v)
  );

  enc_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .x_i      (a_in),
    .y_i      (b_in),
    .negate_i (negate),
    .sum_o    (arith_v)
  );

  enc_alu_less #(.WIDTH(WIDTH)) u_less (
    .x_sign_i    (a_in[MSB]),
    .y_sign_i    (b_in[MSB]),
    .diff_sign_i (arith_v[MSB]),
    .less_o      (less)
  );

  always_comb begin
    case (op_sel)
      OP_AND:  result_out = and_v;
      OP_OR:   result_out = or_v;
      OP_ADD:  result_out = arith_v;
      OP_SUB:  result_out = arith_v;
      OP_SLT:  result_out = {{(WIDTH-1){1'b0}}, less};
      default: result_out = '0;
    endcase
  end

  enc_alu_zero #(.WIDTH(WIDTH), .CHUNK(ZCHUNK)) u_zero (
    .vec_i  (result_out),
    .zero_o (zero_out)
  );
endmodule

// File: rtl/enc_alu_chk.sv
module enc_alu_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [3:0]       op_sel,
  input logic [WIDTH-1:0] result_out,
  input logic             zero_out
);
  localparam int unsigned MSB = WIDTH - 1;

  always_comb begin
    // R3: undoing the addition recovers the first operand
    if (op_sel == 4'b0010)
      a_r3_add_inverse: assert ((result_out - b_in) == a_in);
    // R4: adding the subtrahend back recovers the first operand
    if (op_sel == 4'b0110)
      a_r4_sub_inverse: assert ((result_out + b_in) == a_in);
    // R5: compare output is confined to bit 0
    if (op_sel == 4'b0111)
      a_r5_slt_narrow: assert (result_out[MSB:1] == '0);
    // R5: equal operands are never less
    if (op_sel == 4'b0111 && a_in == b_in)
      a_r5_slt_equal: assert (result_out == '0);
    // R5: a negative operand against a non-negative one decides by sign alone
    if (op_sel == 4'b0111 && a_in[MSB] != b_in[MSB])
      a_r5_slt_sign: assert (result_out[0] == a_in[MSB]);
    // R1: AND never sets a bit absent from either operand
    if (op_sel == 4'b0000)
      a_r1_and_subset: assert ((result_out & ~(a_in & b_in)) == '0);
    // R6: undefined codes give zero
    if (!(op_sel inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111}))
      a_r6_undef_zero: assert (result_out == '0 && zero_out);
    // R7: flag and result agree
    a_r7_zero_flag: assert (zero_out == (result_out == '0));
  end
endmodule

bind enc_alu enc_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_in       (a_in),
  .b_in       (b_in),
  .op_sel     (op_sel),
  .result_out (result_out),
  .zero_out   (zero_out)
);

// File: tb/sim_enc_alu.sv
`timescale 1ns/1ps
module sim_enc_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a, b, res;
  logic [3:0]  op;
  logic        zf;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  enc_alu u0 (
    .a_in       (a),
    .b_in       (b),
    .op_sel     (op),
    .result_out (res),
    .zero_out   (zf)
  );

  function automatic logic [31:0] model(input logic [31:0] x, input logic [31:0] y,
                                        input logic [3:0] c);
    case (c)
      4'b0000: return x & y;
      4'b0001: return x | y;
      4'b0010: return x + y;
      4'b0110: return x - y;
      4'b0111: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic apply_check(input logic [31:0] x, input logic [31:0] y, input logic [3:0] c,
                             input string tag);
    logic [31:0] exp_r;
    @(posedge clk);
    a = x; b = y; op = c;
    @(negedge clk);
    exp_r = model(x, y, c);
    checks++;
    if (res !== exp_r) begin
      failures++;
      $display("FAIL %s %s op=%b a=%h b=%h result actual=%h expected=%h",
               req_of(c), tag, c, x, y, res, exp_r);
    end
    checks++;
    if (zf !== (exp_r == 32'd0)) begin
      failures++;
      $display("FAIL R7 %s op=%b zero actual=%b expected=%b", tag, c, zf, exp_r == 32'd0);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [3:0] ops [8];
    logic [31:0] first_r;
    ops[0] = 4'b0000; ops[1] = 4'b0001; ops[2] = 4'b0010; ops[3] = 4'b0110;
    ops[4] = 4'b0111; ops[5] = 4'b0011; ops[6] = 4'b1111; ops[7] = 4'b0100;
    a = '0; b = '0; op = 4'b0000;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Initial state: all-zero inputs give zero result, flag high (R1, R7)
    @(negedge clk);
    checks++;
    if (res !== 32'd0 || zf !== 1'b1) begin
      failures++;
      $display("FAIL R7 initial actual=%h/%b expected=0/1", res, zf);
    end
    // Directed corners
    apply_check(32'hF0F0_A5A5, 32'h0FF0_FFFF, 4'b0000, "R1 mask");
    apply_check(32'hF0F0_0000, 32'h0F0F_0000, 4'b0000, "R1 disjoint");
    apply_check(32'h1234_0000, 32'h0000_5678, 4'b0001, "R2 merge");
    apply_check(32'h0, 32'h0, 4'b0001, "R2 zero");
    apply_check(32'hFFFF_FFFF, 32'h1, 4'b0010, "R3 wrap");
    apply_check(32'h7FFF_FFFF, 32'h1, 4'b0010, "R3 signed wrap");
    apply_check(32'h0, 32'h1, 4'b0110, "R4 borrow");
    apply_check(32'h8000_0000, 32'h1, 4'b0110, "R4 min wrap");
    apply_check(32'h1234_5678, 32'h1234_5678, 4'b0110, "R4 equal");
    apply_check(32'h8000_0000, 32'h7FFF_FFFF, 4'b0111, "R5 overflow diff");
    apply_check(32'h7FFF_FFFF, 32'h8000_0000, 4'b0111, "R5 overflow diff rev");
    apply_check(32'hFFFF_FFFF, 32'h0, 4'b0111, "R5 minus one");
    apply_check(32'h5, 32'h5, 4'b0111, "R5 equal");
    apply_check(32'h3, 32'h9, 4'b0111, "R5 small");
    apply_check(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0011, "R6 code3");
    apply_check(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b1000, "R6 code8");
    apply_check(32'hDEAD_BEEF, 32'h1, 4'b0101, "R6 code5");
    // R8: same inputs after different history give the same output
    apply_check(32'hCAFE_0001, 32'h0000_7777, 4'b0010, "R8 first");
    first_r = res;
    apply_check(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0001, "R8 disturb");
    apply_check(32'hCAFE_0001, 32'h0000_7777, 4'b0010, "R8 repeat");
    checks++;
    if (res !== first_r) begin
      failures++;
      $display("FAIL R8 history actual=%h expected=%h", res, first_r);
    end
    // Constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] x, y;
      logic [3:0]  c;
      x = $urandom();
      y = ($urandom_range(0, 7) == 0) ? x : $urandom();
      if ($urandom_range(0, 9) == 0) x = {x[31], 31'd0};
      c = ($urandom_range(0, 15) == 0) ? 4'($urandom()) : ops[$urandom_range(0, 7)];
      apply_check(x, y, c, "random");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule